// File: doc/BRIEF.md
# Retimed Manchester Line Encoder

This block turns a serial NRZ bit stream into Manchester symbols for a single-ended line. It runs from one master clock at twice the bit rate. A toggle register inside the block splits each bit period into a first half and a second half. The data bit and its valid flag are sampled once, at the edge that opens a bit period, and held for both halves. The bit is combined with a half-bit phase signal that is high in the first half. The result never goes straight to the line: it is captured in a flip-flop on the double-rate clock. Because of this, a data edge that arrives late relative to the bit clock cannot produce a short pulse just before a symbol begins.

The upstream logic drives the bit and its valid flag before the edge that opens each bit period. The block reports, one cycle later, the registered line level and a one-cycle marker on the first half of every encoded symbol. The reset input asserts asynchronously. Its release passes through a short synchronizer, so the position of the first bit period is fixed relative to reset release.

Top module: `manchester_retimed_tx`

## Requirements
- R1: While rst_n is low, line_out and sym_start are 0, and they drop to 0 without waiting for a clock edge.
- R2: After rst_n rises, the block ignores the next SYNC_STAGES rising edges (default 2). The first bit is sampled at rising edge SYNC_STAGES+1.
- R3: Bit periods are two clk2x cycles long. From the first sampling edge onward, every second rising edge samples bit_in and bit_valid.
- R4: A valid bit of 0 puts line_out high for the first clk2x cycle of its symbol and low for the second.
- R5: A valid bit of 1 puts line_out low for the first clk2x cycle of its symbol and high for the second.
- R6: The first half of a symbol appears on line_out right after the sampling edge, which is a latency of exactly one clk2x cycle. The second half follows on the next edge.
- R7: Values of bit_in and bit_valid that are presented at the edge opening the second half of a bit period have no effect on that symbol.
- R8: If bit_valid is 0 at a sampling edge, line_out stays low for both halves of that bit period and sym_start stays 0.
- R9: sym_start is 1 for exactly the first clk2x cycle of each valid symbol and 0 at all other times.
- R10: Asserting rst_n in the middle of a symbol restarts the bit-period alignment. After the release, the timing of R2 applies again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk2x | input | 1 | Master clock at twice the bit rate |
| rst_n | input | 1 | Active-low reset, asynchronous assert, synchronized release |
| bit_in | input | 1 | NRZ data bit, sampled at the edge opening a bit period |
| bit_valid | input | 1 | Marks bit_in as a bit to send; when low the line idles low |
| line_out | output | 1 | Registered Manchester line level |
| sym_start | output | 1 | One-cycle marker on the first half of each encoded symbol |

## Verification
The half-bit phase register drives everything else. If it is wrong, the encoder samples on the wrong edge, and the line pattern of every symbol that follows appears one clk2x cycle out of place. A long run of identical bits hides this, but the first bit change exposes it within two cycles. A hold register that is stuck or loaded on the wrong edge shows up as a second half that does not mirror the first half of the same symbol. It also shows up as second-half data changes that leak onto the line. Both are visible in the same bit period. A wrong synchronizer depth moves the first symbol after reset, so the first bit period after release shows it.

// File: rtl/mte_pkg.sv
package mte_pkg;
  // Half of the bit period currently being encoded
  typedef enum logic {
    HALF_A = 1'b0,  // first half: sampling edge for new data
    HALF_B = 1'b1   // second half: held data is used
  } half_e;
endpackage

// File: rtl/mte_rst_sync.sv
module mte_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  generate
    if (STAGES == 1) begin : g_single
      always_comb sync_d = 1'b1;
    end else begin : g_chain
      always_comb sync_d = {sync_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/mte_phase_gen.sv
module mte_phase_gen
  import mte_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  output half_e half,
  output logic  first_half
);
  half_e half_q;
  half_e half_d;

  always_comb begin
    half_d = (half_q == HALF_A) ? HALF_B : HALF_A;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) half_q <= HALF_A;
    else        half_q <= half_d;
  end

  assign half       = half_q;
  assign first_half = (half_q == HALF_A);
endmodule

// File: rtl/mte_bit_hold.sv
module mte_bit_hold (
  input  logic clk,
  input  logic rst_n,
  input  logic first_half,
  input  logic bit_in,
  input  logic bit_valid,
  output logic cur_bit,
  output logic cur_vld,
  output logic hold_vld
);
  logic bit_q, vld_q;
  logic bit_d, vld_d;

  // load enable: only the edge opening a bit period captures new data
  always_comb begin
    bit_d = bit_q;
    vld_d = vld_q;
    if (first_half) begin
      bit_d = bit_in;
      vld_d = bit_valid;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bit_q <= 1'b0;
      vld_q <= 1'b0;
    end else begin
      bit_q <= bit_d;
      vld_q <= vld_d;
    end
  end

  // first half uses the live inputs, second half uses the held copy
  assign cur_bit  = first_half ? bit_in    : bit_q;
  assign cur_vld  = first_half ? bit_valid : vld_q;
  assign hold_vld = vld_q;
endmodule

// File: rtl/mte_retime.sv
module mte_retime (
  input  logic clk,
  input  logic rst_n,
  input  logic first_half,
  input  logic cur_bit,
  input  logic cur_vld,
  output logic line_out,
  output logic sym_start
);
  logic line_q, start_q;
  logic line_d, start_d;
  logic phase_clk;

  // phase clock is high during the first half of the bit period
  assign phase_clk = first_half;

  always_comb begin
    line_d  = cur_vld & (cur_bit ^ phase_clk);
    start_d = cur_vld & first_half;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q  <= 1'b0;
      start_q <= 1'b0;
    end else begin
      line_q  <= line_d;
      start_q <= start_d;
    end
  end

  assign line_out  = line_q;
  assign sym_start = start_q;
endmodule

// File: rtl/manchester_retimed_tx.sv
module manchester_retimed_tx
  import mte_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk2x,
  input  logic rst_n,
  input  logic bit_in,
  input  logic bit_valid,
  output logic line_out,
  output logic sym_start
);
  logic  rst_int_n;
  half_e half;
  logic  first_half;
  logic  cur_bit, cur_vld, hold_vld;

  mte_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk        (clk2x),
    .arst_n     (rst_n),
    .rst_sync_n (rst_int_n)
  );

  mte_phase_gen u_phase (
    .clk        (clk2x),
    .rst_n      (rst_int_n),
    .half       (half),
    .first_half (first_half)
  );

  mte_bit_hold u_hold (
    .clk        (clk2x),
    .rst_n      (rst_int_n),
    .first_half (first_half),
    .bit_in     (bit_in),
    .bit_valid  (bit_valid),
    .cur_bit    (cur_bit),
    .cur_vld    (cur_vld),
    .hold_vld   (hold_vld)
  );

  mte_retime u_retime (
    .clk        (clk2x),
    .rst_n      (rst_int_n),
    .first_half (first_half),
    .cur_bit    (cur_bit),
    .cur_vld    (cur_vld),
    .line_out   (line_out),
    .sym_start  (sym_start)
  );
endmodule

// File: rtl/mte_checker.sv
module mte_checker (
  input logic clk2x,
  input logic rst_int_n,
  input logic first_half,
  input logic hold_vld,
  input logic bit_in,
  input logic bit_valid,
  input logic line_out,
  input logic sym_start
);
  // R3: halves alternate every cycle
  assert_half_alternates_R3: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    first_half |=> !first_half);

  // R4 / R5 / R6: first half is the complement of the bit sampled one edge earlier
  assert_first_half_level_R6: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    (first_half && bit_valid) |=> (line_out == !$past(bit_in)));

  // R8: an invalid sample keeps the line low in the first half
  assert_idle_first_R8: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    (first_half && !bit_valid) |=> (!line_out && !sym_start));

  // R8: an invalid held sample keeps the line low in the second half
  assert_idle_second_R8: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    (!first_half && !hold_vld) |=> !line_out);

  // R9: marker lasts one cycle and only appears in the second-half phase state
  assert_start_single_R9: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    sym_start |=> !sym_start);
  assert_start_phase_R9: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    sym_start |-> !first_half);

  // R4 / R5: the second half mirrors the first half of every valid symbol
  assert_mid_transition_R4: assert property (@(posedge clk2x) disable iff (!rst_int_n)
    sym_start |=> (line_out != $past(line_out)));
endmodule

bind manchester_retimed_tx mte_checker u_mte_checker (
  .clk2x      (clk2x),
  .rst_int_n  (rst_int_n),
  .first_half (first_half),
  .hold_vld   (hold_vld),
  .bit_in     (bit_in),
  .bit_valid  (bit_valid),
  .line_out   (line_out),
  .sym_start  (sym_start)
);

// File: tb/manchester_retimed_tx_bench.sv
`timescale 1ns/1ps
module manchester_retimed_tx_bench;
  localparam int SYNC = 2;

  logic clk2x = 1'b0;
  logic rst_n;
  logic bit_in;
  logic bit_valid;
  logic line_out;
  logic sym_start;

  int checks   = 0;
  int failures = 0;

  always #2 clk2x = ~clk2x;  // 250 MHz

  manchester_retimed_tx #(.SYNC_STAGES(SYNC)) u_manchester_retimed_tx (
    .clk2x     (clk2x),
    .rst_n     (rst_n),
    .bit_in    (bit_in),
    .bit_valid (bit_valid),
    .line_out  (line_out),
    .sym_start (sym_start)
  );

  function automatic logic exp_first(input logic b, input logic v);
    return v ? ~b : 1'b0;
  endfunction

  function automatic logic exp_second(input logic b, input logic v);
    return v ? b : 1'b0;
  endfunction

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  // one bit period; second-half inputs are junk that must be ignored (R7)
  task automatic send(input logic b, input logic v, input logic jb, input logic jv);
    @(negedge clk2x);
    bit_in = b; bit_valid = v;
    @(posedge clk2x); #1;
    check("R6", line_out, exp_first(b, v), "first half line");
    check("R9", sym_start, v, "first half marker");
    @(negedge clk2x);
    bit_in = jb; bit_valid = jv;
    @(posedge clk2x); #1;
    check("R7", line_out, exp_second(b, v), "second half line");
    check("R9", sym_start, 1'b0, "second half marker");
  endtask

  // assert reset, release, ride out the synchronizer (R2)
  task automatic do_reset();
    @(negedge clk2x);
    rst_n = 1'b0; bit_in = 1'b0; bit_valid = 1'b1;
    #0.5;
    check("R1", line_out, 1'b0, "line in reset");
    check("R1", sym_start, 1'b0, "marker in reset");
    repeat (3) @(posedge clk2x);
    @(negedge clk2x);
    rst_n = 1'b1;
    for (int i = 0; i < SYNC; i++) begin
      @(posedge clk2x); #1;
      check("R2", line_out, 1'b0, "line during sync");
      check("R2", sym_start, 1'b0, "marker during sync");
    end
  endtask

  initial begin
    #600000;
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'h1f2e3d4c));
    rst_n = 1'b0; bit_in = 1'b0; bit_valid = 1'b0;
    #1;
    check("R1", line_out, 1'b0, "line at time zero");
    check("R1", sym_start, 1'b0, "marker at time zero");
    do_reset();

    // directed: both bit values, with opposing junk in the second half
    send(1'b0, 1'b1, 1'b1, 1'b0);  // R4
    send(1'b1, 1'b1, 1'b0, 1'b0);  // R5
    send(1'b1, 1'b1, 1'b0, 1'b1);  // R5 repeated ones
    send(1'b0, 1'b1, 1'b1, 1'b1);  // R4
    send(1'b1, 1'b0, 1'b1, 1'b1);  // R8 invalid
    send(1'b0, 1'b0, 1'b0, 1'b1);  // R8 invalid
    send(1'b0, 1'b1, 1'b0, 1'b0);  // R3 stays aligned after idle

    // R10: reset in the middle of a symbol
    @(negedge clk2x);
    bit_in = 1'b1; bit_valid = 1'b1;
    @(posedge clk2x); #1;
    check("R5", line_out, 1'b0, "first half before abort");
    do_reset();  // R10: checks R1 asynchronously and R2 alignment
    send(1'b1, 1'b1, 1'b0, 1'b0);  // R10 alignment restored
    send(1'b0, 1'b1, 1'b1, 1'b1);

    // random stream
    for (int n = 0; n < 400; n++) begin
      logic b, v, jb, jv;
      b  = 1'($urandom);
      v  = ($urandom % 4) != 0;
      jb = 1'($urandom);
      jv = 1'($urandom);
      send(b, v, jb, jv);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule